// File: doc/BRIEF.md
# DMA Channel State Register File

This block holds the per-channel state of a descriptor-driven packet DMA that has `NUM_CH` transmit and `NUM_CH` receive channels (eight of each by default). Each channel keeps two 32-bit words. The head pointer is the address of the first descriptor in the channel's queue. The completion pointer is the last descriptor the engine has finished. The host reaches all of these words through a word-indexed write port and a combinational read port. The DMA engine uses its own side-band port to post completion pointers and to empty head pointers.

When the host loads a descriptor address into an empty head pointer, the channel is started. The block sends a one-cycle start pulse together with the pointer value. Loading a head pointer that still holds a value counts as a host error. That write is dropped, and the first such error is captured in a sticky flag. The engine raises a channel interrupt when it posts a completion pointer. The host acknowledges the interrupt by writing back the completion value it has processed. That host write is never stored. It is only compared with the posted value, and the interrupt drops only when the two are equal.

Top module: `dma_chan_state_regs`

## Requirements
- R1: After reset, every word reads 0, all interrupt lines and start lines are low, and the error flag is low.
- R2: Word index layout, with `ch` in 0..NUM_CH-1 and the byte offset equal to 4 × index. Transmit head pointers are at index `ch`. Receive head pointers are at `NUM_CH+ch`. Transmit completion pointers are at `2*NUM_CH+ch`. Receive completion pointers are at `3*NUM_CH+ch`. Reads are combinational from `host_word_i`.
- R3: A host write to a head pointer that holds 0 is accepted and stored. If the written value is non-zero, the start bit of that channel (in `tx_start_o` or `rx_start_o`) is high for exactly the one cycle after the write, and `start_ptr_o` carries the written value. A write of 0 is accepted but starts nothing.
- R4: A host write to a head pointer that holds a non-zero value is discarded and gives no start. It raises `err_o`. The first error is held until reset: `err_rx_o` is 0 for transmit and 1 for receive, and `err_ch_o` holds the channel. Later errors do not change these values.
- R5: An engine clear (`eng_hd_clr_i`) sets the selected head pointer to 0. A following host write to that head pointer is accepted without an error.
- R6: An engine completion write stores its value. The host reads that value back, and the channel's interrupt is high from the next cycle.
- R7: A host write to a completion pointer leaves the stored value unchanged. The interrupt drops on the next cycle if the written value equals the stored value, and otherwise stays high.
- R8: If the engine and the host write the same completion pointer in the same cycle, the engine write wins: its value is stored and the interrupt is high.
- R9: A write to one channel and direction leaves every other channel's words and lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_word_i | input | CH_W+2 | Host word index |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Read data of the word at `host_word_i` |
| eng_cp_we_i | input | 1 | Engine completion pointer write |
| eng_cp_rx_i | input | 1 | Completion write direction (0 transmit, 1 receive) |
| eng_cp_ch_i | input | CH_W | Completion write channel |
| eng_cp_data_i | input | DW | Completion pointer value |
| eng_hd_clr_i | input | 1 | Engine head pointer clear |
| eng_hd_rx_i | input | 1 | Clear direction (0 transmit, 1 receive) |
| eng_hd_ch_i | input | CH_W | Clear channel |
| tx_start_o | output | NUM_CH | Transmit start pulses |
| rx_start_o | output | NUM_CH | Receive start pulses |
| start_ptr_o | output | DW | Head pointer that goes with the start pulse |
| tx_irq_o | output | NUM_CH | Transmit channel interrupts |
| rx_irq_o | output | NUM_CH | Receive channel interrupts |
| err_o | output | 1 | Sticky head-write error flag |
| err_rx_o | output | 1 | Direction of the first error |
| err_ch_o | output | CH_W | Channel of the first error |

## Verification
Some properties are checked by assertions on every cycle. The error flag, once raised, stays raised. At most one start line fires, and only after a host write. An interrupt rises only after an engine completion write, and falls only after a host write to a completion pointer. The bench scenarios cover the value-dependent behaviour: the address layout, the dropped head write and the contents of the captured error, acceptance after an engine clear, the comparison that does or does not acknowledge an interrupt, and the engine winning a same-cycle collision.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  typedef enum logic [1:0] {
    RG_TX_HEAD = 2'd0,
    RG_RX_HEAD = 2'd1,
    RG_TX_COMP = 2'd2,
    RG_RX_COMP = 2'd3
  } region_e;

  function automatic int unsigned ch_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_head_bank.sv
module dma_head_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned CH_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [CH_W-1:0]            wr_ch_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       clr_i,
  input  logic [CH_W-1:0]            clr_ch_i,
  output logic [NUM_CH-1:0][DW-1:0]  head_o,
  output logic [NUM_CH-1:0]          start_o,
  output logic [DW-1:0]              start_ptr_o,
  output logic                       reject_o
);
  logic [DW-1:0]     head_q [NUM_CH];
  logic [NUM_CH-1:0] accept;
  logic [NUM_CH-1:0] start_q;
  logic [DW-1:0]     ptr_q;

  assign reject_o = wr_i && (head_o[wr_ch_i] != '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign accept[c] = wr_i && (wr_ch_i == CH_W'(c)) && (head_q[c] == '0);
    assign head_o[c] = head_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                head_q[c] <= '0;
      else if (accept[c])                         head_q[c] <= wr_data_i;
      else if (clr_i && (clr_ch_i == CH_W'(c)))   head_q[c] <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      ptr_q   <= '0;
    end else begin
      start_q <= accept & {NUM_CH{wr_data_i != '0}};
      if (|accept) ptr_q <= wr_data_i;
    end
  end

  assign start_o     = start_q;
  assign start_ptr_o = ptr_q;
endmodule

// File: rtl/dma_comp_bank.sv
module dma_comp_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned CH_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       eng_we_i,
  input  logic [CH_W-1:0]            eng_ch_i,
  input  logic [DW-1:0]              eng_data_i,
  input  logic                       host_we_i,
  input  logic [CH_W-1:0]            host_ch_i,
  input  logic [DW-1:0]              host_data_i,
  output logic [NUM_CH-1:0][DW-1:0]  comp_o,
  output logic [NUM_CH-1:0]          irq_o
);
  logic [DW-1:0]     comp_q [NUM_CH];
  logic [NUM_CH-1:0] irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic eng_hit, ack_hit;
    assign eng_hit   = eng_we_i && (eng_ch_i == CH_W'(c));
    // host value is compared, never stored
    assign ack_hit   = host_we_i && (host_ch_i == CH_W'(c)) && (host_data_i == comp_q[c]);
    assign comp_o[c] = comp_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        comp_q[c] <= '0;
        irq_q[c]  <= 1'b0;
      end else if (eng_hit) begin
        comp_q[c] <= eng_data_i;
        irq_q[c]  <= 1'b1;
      end else if (ack_hit) begin
        irq_q[c]  <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture #(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rej_tx_i,
  input  logic            rej_rx_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            err_o,
  output logic            err_rx_o,
  output logic [CH_W-1:0] err_ch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      err_rx_o <= 1'b0;
      err_ch_o <= '0;
    end else if (!err_o && (rej_tx_i || rej_rx_i)) begin
      err_o    <= 1'b1;
      err_rx_o <= rej_rx_i;
      err_ch_o <= ch_i;
    end
  end
endmodule

// File: rtl/dma_chan_state_regs.sv
module dma_chan_state_regs
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned CH_W   = ch_width(NUM_CH),
  parameter int unsigned WW     = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [WW-1:0]     host_word_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  input  logic              eng_cp_we_i,
  input  logic              eng_cp_rx_i,
  input  logic [CH_W-1:0]   eng_cp_ch_i,
  input  logic [DW-1:0]     eng_cp_data_i,
  input  logic              eng_hd_clr_i,
  input  logic              eng_hd_rx_i,
  input  logic [CH_W-1:0]   eng_hd_ch_i,
  output logic [NUM_CH-1:0] tx_start_o,
  output logic [NUM_CH-1:0] rx_start_o,
  output logic [DW-1:0]     start_ptr_o,
  output logic [NUM_CH-1:0] tx_irq_o,
  output logic [NUM_CH-1:0] rx_irq_o,
  output logic              err_o,
  output logic              err_rx_o,
  output logic [CH_W-1:0]   err_ch_o
);
  region_e         region;
  logic [CH_W-1:0] host_ch;
  logic            wr_tx_hd, wr_rx_hd, wr_tx_cp, wr_rx_cp;
  logic            rej_tx, rej_rx;
  logic [DW-1:0]   tx_ptr, rx_ptr;

  logic [NUM_CH-1:0][DW-1:0] tx_head, rx_head, tx_comp, rx_comp;

  assign region  = region_e'(host_word_i[WW-1:CH_W]);
  assign host_ch = host_word_i[CH_W-1:0];

  assign wr_tx_hd = host_we_i && (region == RG_TX_HEAD);
  assign wr_rx_hd = host_we_i && (region == RG_RX_HEAD);
  assign wr_tx_cp = host_we_i && (region == RG_TX_COMP);
  assign wr_rx_cp = host_we_i && (region == RG_RX_COMP);

  dma_head_bank #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_tx_head (
    .clk_i, .rst_ni,
    .wr_i(wr_tx_hd), .wr_ch_i(host_ch), .wr_data_i(host_wdata_i),
    .clr_i(eng_hd_clr_i && !eng_hd_rx_i), .clr_ch_i(eng_hd_ch_i),
    .head_o(tx_head), .start_o(tx_start_o), .start_ptr_o(tx_ptr), .reject_o(rej_tx)
  );

  dma_head_bank #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_rx_head (
    .clk_i, .rst_ni,
    .wr_i(wr_rx_hd), .wr_ch_i(host_ch), .wr_data_i(host_wdata_i),
    .clr_i(eng_hd_clr_i && eng_hd_rx_i), .clr_ch_i(eng_hd_ch_i),
    .head_o(rx_head), .start_o(rx_start_o), .start_ptr_o(rx_ptr), .reject_o(rej_rx)
  );

  dma_comp_bank #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_tx_comp (
    .clk_i, .rst_ni,
    .eng_we_i(eng_cp_we_i && !eng_cp_rx_i), .eng_ch_i(eng_cp_ch_i), .eng_data_i(eng_cp_data_i),
    .host_we_i(wr_tx_cp), .host_ch_i(host_ch), .host_data_i(host_wdata_i),
    .comp_o(tx_comp), .irq_o(tx_irq_o)
  );

  dma_comp_bank #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_rx_comp (
    .clk_i, .rst_ni,
    .eng_we_i(eng_cp_we_i && eng_cp_rx_i), .eng_ch_i(eng_cp_ch_i), .eng_data_i(eng_cp_data_i),
    .host_we_i(wr_rx_cp), .host_ch_i(host_ch), .host_data_i(host_wdata_i),
    .comp_o(rx_comp), .irq_o(rx_irq_o)
  );

  dma_err_capture #(.CH_W(CH_W)) u_err (
    .clk_i, .rst_ni,
    .rej_tx_i(rej_tx), .rej_rx_i(rej_rx), .ch_i(host_ch),
    .err_o, .err_rx_o, .err_ch_o
  );

  // only one head write per cycle, so at most one bank holds a fresh pulse
  assign start_ptr_o = (|tx_start_o) ? tx_ptr : rx_ptr;

  always_comb begin
    unique case (region)
      RG_TX_HEAD: host_rdata_o = tx_head[host_ch];
      RG_RX_HEAD: host_rdata_o = rx_head[host_ch];
      RG_TX_COMP: host_rdata_o = tx_comp[host_ch];
      default:    host_rdata_o = rx_comp[host_ch];
    endcase
  end
endmodule

// File: rtl/dma_chan_state_regs_chk.sv
module dma_chan_state_regs_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned WW     = CH_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic [WW-1:0]     host_word_i,
  input logic              eng_cp_we_i,
  input logic              eng_cp_rx_i,
  input logic [CH_W-1:0]   eng_cp_ch_i,
  input logic [NUM_CH-1:0] tx_start_o,
  input logic [NUM_CH-1:0] rx_start_o,
  input logic [NUM_CH-1:0] tx_irq_o,
  input logic [NUM_CH-1:0] rx_irq_o,
  input logic              err_o
);
  logic head_wr, comp_wr, eng_tx, eng_rx;
  assign head_wr = host_we_i && !host_word_i[WW-1];
  assign comp_wr = host_we_i &&  host_word_i[WW-1];
  assign eng_tx  = eng_cp_we_i && !eng_cp_rx_i;
  assign eng_rx  = eng_cp_we_i &&  eng_cp_rx_i;

  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_err_needs_head_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_wr |=> !$rose(err_o));

  assert_start_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_start_o, rx_start_o}));

  assert_start_needs_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_wr |=> ({tx_start_o, rx_start_o} == '0));

  assert_tx_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_tx |=> tx_irq_o[$past(eng_cp_ch_i)]);

  assert_rx_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rx |=> rx_irq_o[$past(eng_cp_ch_i)]);

  assert_tx_irq_rise_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_tx |=> ((tx_irq_o & ~$past(tx_irq_o)) == '0));

  assert_rx_irq_rise_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_rx |=> ((rx_irq_o & ~$past(rx_irq_o)) == '0));

  assert_irq_fall_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_wr |=> ((($past(tx_irq_o) & ~tx_irq_o) == '0) && (($past(rx_irq_o) & ~rx_irq_o) == '0)));
endmodule

bind dma_chan_state_regs dma_chan_state_regs_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .WW(WW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_we_i(host_we_i), .host_word_i(host_word_i),
  .eng_cp_we_i(eng_cp_we_i), .eng_cp_rx_i(eng_cp_rx_i), .eng_cp_ch_i(eng_cp_ch_i),
  .tx_start_o(tx_start_o), .rx_start_o(rx_start_o),
  .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o), .err_o(err_o)
);

// File: tb/dma_chan_state_regs_tb.sv
module dma_chan_state_regs_tb;
  localparam int N  = 8;
  localparam int CW = 3;
  localparam int WW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic          host_we = 0;
  logic [WW-1:0] host_word = '0;
  logic [31:0]   host_wdata = '0, host_rdata;
  logic          eng_cp_we = 0, eng_cp_rx = 0, eng_hd_clr = 0, eng_hd_rx = 0;
  logic [CW-1:0] eng_cp_ch = '0, eng_hd_ch = '0;
  logic [31:0]   eng_cp_data = '0;
  logic [N-1:0]  tx_start, rx_start, tx_irq, rx_irq;
  logic [31:0]   start_ptr;
  logic          err, err_rx;
  logic [CW-1:0] err_ch;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_chan_state_regs #(.NUM_CH(N), .DW(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_word_i(host_word), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .eng_cp_we_i(eng_cp_we), .eng_cp_rx_i(eng_cp_rx), .eng_cp_ch_i(eng_cp_ch), .eng_cp_data_i(eng_cp_data),
    .eng_hd_clr_i(eng_hd_clr), .eng_hd_rx_i(eng_hd_rx), .eng_hd_ch_i(eng_hd_ch),
    .tx_start_o(tx_start), .rx_start_o(rx_start), .start_ptr_o(start_ptr),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .err_o(err), .err_rx_o(err_rx), .err_ch_o(err_ch)
  );

  function automatic logic [WW-1:0] w_txh(int ch); return WW'(ch);       endfunction
  function automatic logic [WW-1:0] w_rxh(int ch); return WW'(N + ch);   endfunction
  function automatic logic [WW-1:0] w_txc(int ch); return WW'(2*N + ch); endfunction
  function automatic logic [WW-1:0] w_rxc(int ch); return WW'(3*N + ch); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [WW-1:0] w, output logic [31:0] d);
    host_word = w;
    #0.5;
    d = host_rdata;
  endtask

  // write is captured at the next posedge; returns half a cycle later
  task automatic hwr(input logic [WW-1:0] w, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_word = w; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic eng_cp(input bit rx, input int ch, input logic [31:0] d);
    @(negedge clk);
    eng_cp_we = 1; eng_cp_rx = rx; eng_cp_ch = CW'(ch); eng_cp_data = d;
    @(negedge clk);
    eng_cp_we = 0;
  endtask

  task automatic eng_clr(input bit rx, input int ch);
    @(negedge clk);
    eng_hd_clr = 1; eng_hd_rx = rx; eng_hd_ch = CW'(ch);
    @(negedge clk);
    eng_hd_clr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d, acc;
    acc = '0;
    for (int w = 0; w < 4*N; w++) begin
      rd(WW'(w), d);
      acc |= d;
    end
    chk("R1 all words zero", acc, 0);
    chk("R1 irq low", {16'h0, tx_irq, rx_irq}, 0);
    chk("R1 start low", {16'h0, tx_start, rx_start}, 0);
    chk("R1 err low", {31'h0, err}, 0);
  endtask

  task automatic t_tx_start();
    logic [31:0] d;
    hwr(w_txh(3), 32'h0000_1000);
    chk("R3 tx start pulse", {24'h0, tx_start}, 32'h08);
    chk("R3 start ptr", start_ptr, 32'h0000_1000);
    chk("R9 rx start quiet", {24'h0, rx_start}, 0);
    @(negedge clk);
    chk("R3 pulse one cycle", {24'h0, tx_start}, 0);
    rd(w_txh(3), d); chk("R2 tx head ch3 readback", d, 32'h0000_1000);
    rd(w_rxh(3), d); chk("R9 rx head ch3 untouched", d, 0);
    rd(w_txh(2), d); chk("R9 tx head ch2 untouched", d, 0);
  endtask

  task automatic t_rx_start();
    logic [31:0] d;
    hwr(w_rxh(5), 32'h2000_0040);
    chk("R3 rx start pulse", {24'h0, rx_start}, 32'h20);
    chk("R3 rx start ptr", start_ptr, 32'h2000_0040);
    rd(w_rxh(5), d); chk("R2 rx head ch5 readback", d, 32'h2000_0040);
  endtask

  task automatic t_zero_write();
    hwr(w_txh(0), 32'h0);
    chk("R3 zero write no start", {16'h0, tx_start, rx_start}, 0);
    chk("R3 zero write no err", {31'h0, err}, 0);
  endtask

  task automatic t_error();
    logic [31:0] d;
    hwr(w_txh(3), 32'h0000_5555);
    chk("R4 rejected write no start", {16'h0, tx_start, rx_start}, 0);
    rd(w_txh(3), d); chk("R4 head unchanged", d, 32'h0000_1000);
    chk("R4 err set", {31'h0, err}, 1);
    chk("R4 err dir tx", {31'h0, err_rx}, 0);
    chk("R4 err ch", {29'h0, err_ch}, 3);
    hwr(w_rxh(5), 32'h0000_7777);
    rd(w_rxh(5), d); chk("R4 rx head unchanged", d, 32'h2000_0040);
    chk("R4 first err kept dir", {31'h0, err_rx}, 0);
    chk("R4 first err kept ch", {29'h0, err_ch}, 3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    eng_clr(0, 3);
    rd(w_txh(3), d); chk("R5 head cleared", d, 0);
    rd(w_rxh(5), d); chk("R9 rx head ch5 kept", d, 32'h2000_0040);
    hwr(w_txh(3), 32'h0000_3000);
    chk("R5 restart pulse", {24'h0, tx_start}, 32'h08);
    rd(w_txh(3), d); chk("R5 new head stored", d, 32'h0000_3000);
    chk("R5 err unchanged ch", {29'h0, err_ch}, 3);
  endtask

  task automatic t_comp();
    logic [31:0] d;
    eng_cp(1, 2, 32'h0000_ABC0);
    chk("R6 rx irq set", {24'h0, rx_irq}, 32'h04);
    chk("R9 tx irq quiet", {24'h0, tx_irq}, 0);
    rd(w_rxc(2), d); chk("R6 comp readback", d, 32'h0000_ABC0);
    hwr(w_rxc(2), 32'h0000_1230);
    chk("R7 mismatch keeps irq", {24'h0, rx_irq}, 32'h04);
    rd(w_rxc(2), d); chk("R7 host value not stored", d, 32'h0000_ABC0);
    hwr(w_rxc(2), 32'h0000_ABC0);
    chk("R7 match clears irq", {24'h0, rx_irq}, 0);
    rd(w_rxc(2), d); chk("R7 value kept after ack", d, 32'h0000_ABC0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    eng_cp(0, 6, 32'h0000_0080);
    chk("R6 tx irq set", {24'h0, tx_irq}, 32'h40);
    @(negedge clk);
    eng_cp_we = 1; eng_cp_rx = 0; eng_cp_ch = 3'd6; eng_cp_data = 32'h0000_0100;
    host_we = 1; host_word = w_txc(6); host_wdata = 32'h0000_0080;
    @(negedge clk);
    eng_cp_we = 0; host_we = 0;
    chk("R8 engine wins irq", {24'h0, tx_irq}, 32'h40);
    rd(w_txc(6), d); chk("R8 engine value stored", d, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_start();
    t_rx_start();
    t_zero_write();
    t_error();
    t_clear();
    t_comp();
    t_collide();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule